// File: doc/BRIEF.md
# Reset and Power Command Register

This block is one 32-bit control word on a simple memory-mapped register bus. Software writes a full word in which individual bits act as commands. A command bit set to 1 fires a reset pulse, one clock wide, toward one subsystem: the sample FIFO, the digital I/O, the analog outputs or the analog input. A further bit resets the whole board. The board reset raises every subsystem reset at once and also returns the converter to the powered-up state.

The word also holds one level bit that keeps the analog-to-digital converter powered down while it is 1. Command bits never stay set, so a read returns only the power-down level, and every other bit reads as 0. Partial-word writes and writes to reserved bits have no effect. A synchronous global reset returns the block to idle with the converter powered up.

Top module: `reset_power_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, all five reset outputs, `adc_pd` and `rd_data` are 0 after that edge.
- R2: A full-word write (`wr_en`=1, `wr_be`=4'hF) with bit 6 set raises `fifo_rst`, bit 5 raises `dio_rst`, bit 3 raises `dac_rst` and bit 1 raises `adc_rst`. Each pulse is high for exactly the one cycle after the write edge, unless the next cycle carries another such write.
- R3: A full-word write with bit 0 set raises `board_rst` together with `fifo_rst`, `dio_rst`, `dac_rst` and `adc_rst` for that one cycle.
- R4: A write with several command bits set raises all of the selected reset outputs in the same cycle.
- R5: Bit 2 of a full-word write loads `adc_pd` (1 = powered down, 0 = powered up) at the write edge. `adc_pd` holds that value until the next full-word write.
- R6: A full-word write with bit 0 set clears `adc_pd` to 0, even when bit 2 of the same word is 1.
- R7: `rd_data` is registered. In the cycle after `rd_en`=1 it carries `adc_pd` in bit 2 and 0 in every other bit, command bits included. A write in the same cycle as the read is not yet visible. In the cycle after `rd_en`=0 it is 0.
- R8: A write with `wr_be` other than 4'hF fires no reset and leaves `adc_pd` unchanged.
- R9: Bits 31 to 7 and bit 4 are reserved. Setting them in a write fires no reset and does not affect `adc_pd`.
- R10: A write presented while `rst` is high fires no reset, and `adc_pd` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high global reset |
| wr_en | input | 1 | Write strobe |
| wr_be | input | 4 | Byte enables; only 4'hF is accepted |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| fifo_rst | output | 1 | One-cycle sample FIFO reset |
| dio_rst | output | 1 | One-cycle digital I/O reset |
| dac_rst | output | 1 | One-cycle analog output reset |
| adc_rst | output | 1 | One-cycle analog input reset |
| board_rst | output | 1 | One-cycle whole-board reset |
| adc_pd | output | 1 | Converter power-down level |

## Verification
The main function is tried with each command bit set alone. These writes show that every bit is routed to its own output and to no other. Words with several command bits and with board reset show that simultaneous pulses fire together and that the board-reset fan-out works, including a word where board reset and power-down are both set. Reserved-bit words, partial byte enables, back-to-back writes, a write during global reset and a read in the same cycle as a write show that the power-down level is kept separate from the self-clearing commands.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  localparam int REG_W     = 32;
  localparam int BE_W      = REG_W / 8;
  localparam int NUM_CMD   = 5;
  localparam int POS_BOARD = 0;
  localparam int POS_PD    = 2;
  // Command slot order: board, adc, dac, dio, fifo. Slot 0 fans out to all others.
  localparam int CMD_POS [NUM_CMD] = '{0, 1, 3, 5, 6};
endpackage

// File: rtl/rpc_write_decode.sv
module rpc_write_decode
  import rpc_pkg::*;
#(
  parameter int DW = REG_W,
  parameter int BW = DW / 8,
  parameter int NC = NUM_CMD
) (
  input  logic          wr_en,
  input  logic [BW-1:0] wr_be,
  input  logic [DW-1:0] wr_data,
  output logic          full_wr,
  output logic [NC-1:0] cmd,
  output logic          pd_val
);
  assign full_wr = wr_en && (wr_be == {BW{1'b1}});
  assign pd_val  = wr_data[POS_PD];

  for (genvar i = 0; i < NC; i++) begin : g_cmd
    assign cmd[i] = full_wr && wr_data[CMD_POS[i]];
  end
endmodule

// File: rtl/rpc_pulse_bank.sv
module rpc_pulse_bank #(
  parameter int NC = rpc_pkg::NUM_CMD
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NC-1:0] cmd,
  output logic [NC-1:0] pulse
);
  for (genvar i = 0; i < NC; i++) begin : g_pulse
    logic fire;
    if (i == 0) begin : g_root
      assign fire = cmd[0];
    end else begin : g_leaf
      assign fire = cmd[i] || cmd[0];
    end
    always_ff @(posedge clk) begin
      if (rst) pulse[i] <= 1'b0;
      else     pulse[i] <= fire;
    end
  end
endmodule

// File: rtl/rpc_level_bit.sv
module rpc_level_bit (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic clr,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= 1'b0;
    else if (clr)  q <= 1'b0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/reset_power_ctrl.sv
module reset_power_ctrl
  import rpc_pkg::*;
#(
  parameter int DW = REG_W,
  parameter int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_be,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          fifo_rst,
  output logic          dio_rst,
  output logic          dac_rst,
  output logic          adc_rst,
  output logic          board_rst,
  output logic          adc_pd
);
  localparam int NC = NUM_CMD;

  logic          full_wr;
  logic [NC-1:0] cmd;
  logic          pd_val;
  logic [NC-1:0] pulse;
  logic [DW-1:0] rd_word;

  rpc_write_decode #(.DW(DW), .BW(BW), .NC(NC)) u_dec (
    .wr_en   (wr_en),
    .wr_be   (wr_be),
    .wr_data (wr_data),
    .full_wr (full_wr),
    .cmd     (cmd),
    .pd_val  (pd_val)
  );

  rpc_pulse_bank #(.NC(NC)) u_pulse (
    .clk   (clk),
    .rst   (rst),
    .cmd   (cmd),
    .pulse (pulse)
  );

  rpc_level_bit u_pd (
    .clk  (clk),
    .rst  (rst),
    .load (full_wr),
    .clr  (cmd[0]),
    .d    (pd_val),
    .q    (adc_pd)
  );

  assign board_rst = pulse[0];
  assign adc_rst   = pulse[1];
  assign dac_rst   = pulse[2];
  assign dio_rst   = pulse[3];
  assign fifo_rst  = pulse[4];

  always_comb begin
    rd_word         = '0;
    rd_word[POS_PD] = adc_pd;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_word;
    else            rd_data <= '0;
  end
endmodule

// File: rtl/rpc_checker.sv
module rpc_checker #(
  parameter int DW = 32,
  parameter int BW = DW / 8
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [BW-1:0] wr_be,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] rd_data,
  input logic          fifo_rst,
  input logic          dio_rst,
  input logic          dac_rst,
  input logic          adc_rst,
  input logic          board_rst,
  input logic          adc_pd
);
  logic full_wr;
  logic any_rst;
  assign full_wr = wr_en && (wr_be == {BW{1'b1}});
  assign any_rst = fifo_rst | dio_rst | dac_rst | adc_rst | board_rst;

  p_fifo_cause_r2: assert property (@(posedge clk) disable iff (rst)
    fifo_rst |-> $past(full_wr && (wr_data[6] || wr_data[0])));

  p_board_fanout_r3: assert property (@(posedge clk) disable iff (rst)
    board_rst |-> (fifo_rst && dio_rst && dac_rst && adc_rst));

  p_pd_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !full_wr |=> $stable(adc_pd));

  p_board_clears_pd_r6: assert property (@(posedge clk) disable iff (rst)
    board_rst |-> !adc_pd);

  p_read_reserved_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~(32'h4)) == '0);

  p_partial_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_be != {BW{1'b1}})) |=> (!any_rst && $stable(adc_pd)));

  p_reset_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!any_rst && !adc_pd));
endmodule

bind reset_power_ctrl rpc_checker #(.DW(DW), .BW(BW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_be     (wr_be),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .fifo_rst  (fifo_rst),
  .dio_rst   (dio_rst),
  .dac_rst   (dac_rst),
  .adc_rst   (adc_rst),
  .board_rst (board_rst),
  .adc_pd    (adc_pd)
);

// File: tb/reset_power_ctrl_tb.sv
module reset_power_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = 4'h0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        fifo_rst, dio_rst, dac_rst, adc_rst, board_rst, adc_pd;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  reset_power_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .fifo_rst(fifo_rst), .dio_rst(dio_rst),
    .dac_rst(dac_rst), .adc_rst(adc_rst), .board_rst(board_rst), .adc_pd(adc_pd)
  );

  // {be, data, pulses {fifo,dio,dac,adc,board}, pd after write}
  localparam int NV = 15;
  localparam logic [41:0] VEC [NV] = '{
    {4'hF, 32'h0000_0040, 5'b10000, 1'b0},
    {4'hF, 32'h0000_0020, 5'b01000, 1'b0},
    {4'hF, 32'h0000_0008, 5'b00100, 1'b0},
    {4'hF, 32'h0000_0002, 5'b00010, 1'b0},
    {4'hF, 32'h0000_0001, 5'b11111, 1'b0},
    {4'hF, 32'h0000_006A, 5'b11110, 1'b0},
    {4'hF, 32'h0000_0004, 5'b00000, 1'b1},
    {4'hF, 32'h0000_0044, 5'b10000, 1'b1},
    {4'h7, 32'h0000_0040, 5'b00000, 1'b1},
    {4'hF, 32'hFFFF_FF94, 5'b00000, 1'b1},
    {4'hF, 32'h0000_0005, 5'b11111, 1'b0},
    {4'hF, 32'h0000_0000, 5'b00000, 1'b0},
    {4'h0, 32'h0000_0004, 5'b00000, 1'b0},
    {4'hF, 32'h0000_0004, 5'b00000, 1'b1},
    {4'hF, 32'h0000_0000, 5'b00000, 1'b0}
  };

  function automatic string vtag(int i);
    case (i)
      0, 1, 2, 3: return "R2";
      4:          return "R3";
      5:          return "R4";
      6, 7, 11, 13, 14: return "R5";
      8, 12:      return "R8";
      9:          return "R9";
      default:    return "R6";
    endcase
  endfunction

  function automatic logic [4:0] pulses();
    return {fifo_rst, dio_rst, dac_rst, adc_rst, board_rst};
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    check("R1", "pulses in reset", {27'b0, pulses()}, 32'h0);
    check("R1", "pd in reset", {31'b0, adc_pd}, 32'h0);
    check("R1", "rd_data in reset", rd_data, 32'h0);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_be = VEC[i][41:38]; wr_data = VEC[i][37:6]; rd_en = 1'b0;
      tick();
      check(vtag(i), "pulses after write", {27'b0, pulses()}, {27'b0, VEC[i][5:1]});
      check(vtag(i), "pd after write", {31'b0, adc_pd}, {31'b0, VEC[i][0]});
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b1;
      tick();
      check("R2", "pulse drops after one cycle", {27'b0, pulses()}, 32'h0);
      check("R7", "read word", rd_data, {29'b0, VEC[i][0], 2'b00});
      @(negedge clk) rd_en = 1'b0;
      tick();
      check("R7", "idle read data", rd_data, 32'h0);
    end

    // back-to-back commands keep the pulse high (R2)
    @(negedge clk); wr_en = 1'b1; wr_be = 4'hF; wr_data = 32'h40;
    tick();
    check("R2", "first of back-to-back", {31'b0, fifo_rst}, 32'h1);
    @(negedge clk); wr_data = 32'h20;
    tick();
    check("R2", "second of back-to-back", {27'b0, pulses()}, 32'h08);
    @(negedge clk); wr_en = 1'b0;
    tick();
    check("R2", "back-to-back end", {27'b0, pulses()}, 32'h0);

    // read in the same cycle as a write sees the old level (R7)
    @(negedge clk); wr_en = 1'b1; wr_data = 32'h4; rd_en = 1'b1;
    tick();
    check("R7", "read beside write", rd_data, 32'h0);
    check("R5", "pd set by write", {31'b0, adc_pd}, 32'h1);
    @(negedge clk); wr_en = 1'b0;
    tick();
    check("R7", "read after write", rd_data, 32'h4);
    @(negedge clk); rd_en = 1'b0;

    // write during global reset (R10)
    @(negedge clk); rst = 1'b1; wr_en = 1'b1; wr_data = 32'h0000_006F;
    tick();
    check("R10", "pulses during reset write", {27'b0, pulses()}, 32'h0);
    check("R10", "pd cleared by reset", {31'b0, adc_pd}, 32'h0);
    @(negedge clk); rst = 1'b0; wr_en = 1'b0;
    tick();
    check("R10", "no late pulse", {27'b0, pulses()}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule